// File: doc/BRIEF.md
# Windowed Integer Register File

This block holds the integer registers of a processor whose register set slides. Software always sees 32 architectural registers of 32 bits. Numbers 0 to 7 are globals, 8 to 15 are outs, 16 to 23 are locals and 24 to 31 are ins. Register 0 is a constant zero. Behind the visible set is a physical array with one shared group of eight globals and `NWIN` windows of sixteen registers each. Every window holds eight locals and eight ins. `NWIN` ranges from 2 to 32.

A current window pointer picks the visible window. The outs of window `w` are the same storage as the ins of window `w-1` (modulo `NWIN`). A caller places arguments in its outs, issues a save, and the callee finds them in its ins.

A save command moves the pointer down by one and a restore command moves it up by one. The operands of that instruction are read in the old window, and its result is written into the new window in the same cycle. An invalid-window mask marks windows that must not be entered. A save into a marked window raises an overflow flag, and a restore into a marked window raises an underflow flag. In both cases the pointer stays where it is and the write of that cycle is dropped.

Top module: `rfw_regfile`

## Requirements
- R1: After reset the pointer is 0, the mask is all zero, both flags are low and every architectural register reads 0 in every window.
- R2: Architectural register 0 reads 0 on both read ports, and a write to it changes nothing.
- R3: Globals 1 to 7 are a single set: a value written in any window is read back unchanged in every other window.
- R4: Locals (16–23) and ins (24–31) are private to their window: a write in window `w` is visible only while the pointer is `w`, except for the alias of R5.
- R5: Out `k` (architectural 8+k) in window `w` is the same storage as in `k` (architectural 24+k) in window `(w-1) mod NWIN`.
- R6: Command encoding on `cmd` is 2'b00 none, 2'b01 save, 2'b10 restore and 2'b11 none. An accepted save sets the pointer to `(cwp-1) mod NWIN`, so 0 wraps to `NWIN-1`. An accepted restore sets it to `(cwp+1) mod NWIN`, so `NWIN-1` wraps to 0. No command leaves it unchanged.
- R7: In a cycle with an accepted save or restore, both read ports use the old pointer and the write port uses the new pointer.
- R8: Reads are combinational. When the write of the current cycle targets the same physical register as a read port, that port returns the write data. Otherwise, written data appears from the next cycle on.
- R9: Bit `i` of the mask marks window `i`. When a save would enter a marked window, `win_ovf` is high in that cycle; when a restore would, `win_unf` is high. In either case the pointer is unchanged and the write of that cycle is discarded. Both flags are combinational, and never high together.
- R10: `mask_wr_en` loads `mask_wr_data` into the mask at the clock edge. The mask is shown on `mask`. The flags of a cycle use the mask value from before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd | input | 2 | Window command: 00 none, 01 save, 10 restore, 11 none |
| rd_a_addr | input | 5 | Architectural number for read port A |
| rd_a_data | output | XLEN | Read data A |
| rd_b_addr | input | 5 | Architectural number for read port B |
| rd_b_data | output | XLEN | Read data B |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 5 | Architectural number for the write |
| wr_data | input | XLEN | Write data |
| mask_wr_en | input | 1 | Load the invalid-window mask |
| mask_wr_data | input | NWIN | New mask value |
| cwp | output | $clog2(NWIN) | Current window pointer |
| mask | output | NWIN | Current invalid-window mask |
| win_ovf | output | 1 | Save blocked by a marked window |
| win_unf | output | 1 | Restore blocked by a marked window |

## Verification
A wrong pointer shows on `cwp` one cycle after the command. It also sends every later read of outs, locals and ins to the wrong slot. A wrong alias between outs and ins shows only when data crosses a save or restore, so the directed sequences pass values both ways across the boundary and across the wrap at window 0. A broken forward or a write using the wrong window shows at once on the read port in the same cycle, or on the first read of that register afterwards. A mask or flag error shows as a flag mismatch in the cycle of the command and as a moved pointer one cycle later.

// File: rtl/rfw_pkg.sv
package rfw_pkg;

    typedef enum logic [1:0] {
        CMD_NONE    = 2'b00,
        CMD_SAVE    = 2'b01,
        CMD_RESTORE = 2'b10,
        CMD_RSVD    = 2'b11
    } win_cmd_e;

    localparam int unsigned ARCH_REGS = 32;
    localparam int unsigned GLOB_REGS = 8;
    localparam int unsigned WIN_REGS  = 16;

endpackage

// File: rtl/rfw_addr_map.sv
module rfw_addr_map #(
    parameter int unsigned NWIN = 8,
    parameter int unsigned CW   = 3,
    parameter int unsigned PW   = 8
) (
    input  logic [4:0]    arch_i,
    input  logic [CW-1:0] win_i,
    output logic [PW-1:0] phys_o
);
    import rfw_pkg::*;

    logic [CW-1:0] prev_win;

    always_comb begin
        int p;
        if (win_i == '0) prev_win = CW'(NWIN - 1);
        else             prev_win = win_i - 1'b1;

        case (arch_i[4:3])
            2'd0:    p = int'(arch_i);
            2'd1:    p = GLOB_REGS + int'(prev_win) * WIN_REGS + 8 + int'(arch_i[2:0]);
            2'd2:    p = GLOB_REGS + int'(win_i) * WIN_REGS + int'(arch_i[2:0]);
            default: p = GLOB_REGS + int'(win_i) * WIN_REGS + 8 + int'(arch_i[2:0]);
        endcase
        phys_o = PW'(p);
    end

endmodule

// File: rtl/rfw_window_ctrl.sv
module rfw_window_ctrl #(
    parameter int unsigned NWIN = 8,
    parameter int unsigned CW   = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      cmd_i,
    input  logic            mask_wr_en_i,
    input  logic [NWIN-1:0] mask_wr_data_i,
    output logic [CW-1:0]   cwp_o,
    output logic [CW-1:0]   tgt_win_o,
    output logic [NWIN-1:0] mask_o,
    output logic            ovf_o,
    output logic            unf_o
);
    import rfw_pkg::*;

    typedef struct packed {
        logic [CW-1:0]   cwp;
        logic [NWIN-1:0] mask;
    } wstate_t;

    wstate_t       st_d, st_q;
    logic [CW-1:0] save_win, rest_win;
    logic          is_save, is_rest;

    always_comb begin
        st_d     = st_q;
        is_save  = (cmd_i == CMD_SAVE);
        is_rest  = (cmd_i == CMD_RESTORE);
        save_win = (st_q.cwp == '0) ? CW'(NWIN - 1) : st_q.cwp - 1'b1;
        rest_win = (st_q.cwp == CW'(NWIN - 1)) ? '0 : st_q.cwp + 1'b1;
        ovf_o    = is_save && st_q.mask[save_win];
        unf_o    = is_rest && st_q.mask[rest_win];
        if (is_save && !ovf_o)      st_d.cwp = save_win;
        else if (is_rest && !unf_o) st_d.cwp = rest_win;
        if (mask_wr_en_i)           st_d.mask = mask_wr_data_i;
        tgt_win_o = st_d.cwp;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cwp_o  = st_q.cwp;
    assign mask_o = st_q.mask;

    a_r6_cwp_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        int'(st_q.cwp) < NWIN);

    a_r6_save_steps_down: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == CMD_SAVE && !ovf_o) |=>
        st_q.cwp == (($past(st_q.cwp) == '0) ? CW'(NWIN - 1) : $past(st_q.cwp) - 1'b1));

    a_r6_restore_steps_up: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == CMD_RESTORE && !unf_o) |=>
        st_q.cwp == (($past(st_q.cwp) == CW'(NWIN - 1)) ? '0 : $past(st_q.cwp) + 1'b1));

    a_r9_trap_holds_cwp: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_o || unf_o) |=> $stable(st_q.cwp));

    a_r9_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(ovf_o && unf_o));

    a_r10_mask_loads: assert property (@(posedge clk) disable iff (!rst_n)
        mask_wr_en_i |=> st_q.mask == $past(mask_wr_data_i));

endmodule

// File: rtl/rfw_storage.sv
module rfw_storage #(
    parameter int unsigned XLEN  = 32,
    parameter int unsigned NPHYS = 136,
    parameter int unsigned PW    = 8,
    parameter int unsigned NRD   = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we_i,
    input  logic [PW-1:0]   widx_i,
    input  logic [XLEN-1:0] wdata_i,
    input  logic [PW-1:0]   ridx_i [NRD],
    output logic [XLEN-1:0] rdata_o [NRD]
);
    logic [XLEN-1:0] regs_d [NPHYS];
    logic [XLEN-1:0] regs_q [NPHYS];
    logic            wr_live;

    assign wr_live = we_i && (widx_i != '0);

    always_comb begin
        regs_d = regs_q;
        if (wr_live) regs_d[widx_i] = wdata_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '{default: '0};
        else        regs_q <= regs_d;
    end

    for (genvar g = 0; g < NRD; g++) begin : g_rd
        always_comb begin
            if (ridx_i[g] == '0)                       rdata_o[g] = '0;
            else if (wr_live && widx_i == ridx_i[g])   rdata_o[g] = wdata_i;
            else                                       rdata_o[g] = regs_q[ridx_i[g]];
        end
    end

    a_r8_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        wr_live |=> regs_q[$past(widx_i)] == $past(wdata_i));

    a_r2_slot_zero_const: assert property (@(posedge clk) disable iff (!rst_n)
        regs_q[0] == '0);

endmodule

// File: rtl/rfw_regfile.sv
module rfw_regfile #(
    parameter int unsigned NWIN = 8,
    parameter int unsigned XLEN = 32,
    localparam int unsigned CW    = (NWIN > 1) ? $clog2(NWIN) : 1,
    localparam int unsigned NPHYS = 8 + 16 * NWIN,
    localparam int unsigned PW    = $clog2(NPHYS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      cmd,
    input  logic [4:0]      rd_a_addr,
    output logic [XLEN-1:0] rd_a_data,
    input  logic [4:0]      rd_b_addr,
    output logic [XLEN-1:0] rd_b_data,
    input  logic            wr_en,
    input  logic [4:0]      wr_addr,
    input  logic [XLEN-1:0] wr_data,
    input  logic            mask_wr_en,
    input  logic [NWIN-1:0] mask_wr_data,
    output logic [CW-1:0]   cwp,
    output logic [NWIN-1:0] mask,
    output logic            win_ovf,
    output logic            win_unf
);
    localparam int unsigned NRD = 2;

    logic [CW-1:0]   cur_win, tgt_win;
    logic [4:0]      rd_arch [NRD];
    logic [PW-1:0]   rd_phys [NRD];
    logic [XLEN-1:0] rd_val  [NRD];
    logic [PW-1:0]   wr_phys;
    logic            wr_ok;

    rfw_window_ctrl #(.NWIN(NWIN), .CW(CW)) u_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .cmd_i          (cmd),
        .mask_wr_en_i   (mask_wr_en),
        .mask_wr_data_i (mask_wr_data),
        .cwp_o          (cur_win),
        .tgt_win_o      (tgt_win),
        .mask_o         (mask),
        .ovf_o          (win_ovf),
        .unf_o          (win_unf)
    );

    assign rd_arch[0] = rd_a_addr;
    assign rd_arch[1] = rd_b_addr;

    for (genvar g = 0; g < NRD; g++) begin : g_rmap
        rfw_addr_map #(.NWIN(NWIN), .CW(CW), .PW(PW)) u_map (
            .arch_i (rd_arch[g]),
            .win_i  (cur_win),
            .phys_o (rd_phys[g])
        );
    end

    rfw_addr_map #(.NWIN(NWIN), .CW(CW), .PW(PW)) u_wmap (
        .arch_i (wr_addr),
        .win_i  (tgt_win),
        .phys_o (wr_phys)
    );

    assign wr_ok = wr_en && !win_ovf && !win_unf;

    rfw_storage #(.XLEN(XLEN), .NPHYS(NPHYS), .PW(PW), .NRD(NRD)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (wr_ok),
        .widx_i  (wr_phys),
        .wdata_i (wr_data),
        .ridx_i  (rd_phys),
        .rdata_o (rd_val)
    );

    assign rd_a_data = rd_val[0];
    assign rd_b_data = rd_val[1];
    assign cwp       = cur_win;

    a_r2_zero_port_a: assert property (@(posedge clk) disable iff (!rst_n)
        rd_a_addr == 5'd0 |-> rd_a_data == '0);

    a_r2_zero_port_b: assert property (@(posedge clk) disable iff (!rst_n)
        rd_b_addr == 5'd0 |-> rd_b_data == '0);

    a_r3_global_window_free: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_a_addr[4:3] == 2'd0) |-> int'(rd_phys[0]) < 8);

endmodule

// File: tb/rfw_regfile_bench.sv
`timescale 1ns/1ps
module rfw_regfile_bench;
    localparam int N    = 8;
    localparam int XLEN = 32;
    localparam int CW   = $clog2(N);
    localparam int MSZ  = 100 + 16 * N;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [1:0]      cmd = '0;
    logic [4:0]      rd_a_addr = '0, rd_b_addr = '0, wr_addr = '0;
    logic [XLEN-1:0] rd_a_data, rd_b_data, wr_data = '0;
    logic            wr_en = 1'b0, mask_wr_en = 1'b0;
    logic [N-1:0]    mask_wr_data = '0;
    logic [CW-1:0]   cwp;
    logic [N-1:0]    mask;
    logic            win_ovf, win_unf;

    int checks = 0;
    int errors = 0;

    logic [31:0] mdl [MSZ];
    int          cwp_m;
    logic [N-1:0] mask_m;
    bit          last_trap;

    always #2.5 clk = ~clk;

    rfw_regfile #(.NWIN(N), .XLEN(XLEN)) u_rfw_regfile (
        .clk(clk), .rst_n(rst_n), .cmd(cmd),
        .rd_a_addr(rd_a_addr), .rd_a_data(rd_a_data),
        .rd_b_addr(rd_b_addr), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .mask_wr_en(mask_wr_en), .mask_wr_data(mask_wr_data),
        .cwp(cwp), .mask(mask), .win_ovf(win_ovf), .win_unf(win_unf)
    );

    task automatic chk(bit ok, string tag, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic int slot(int a, int w);
        if (a < 8)  return a;
        if (a < 16) return 100 + ((w + N - 1) % N) * 16 + 8 + (a - 8);
        if (a < 24) return 100 + w * 16 + (a - 16);
        return 100 + w * 16 + 8 + (a - 24);
    endfunction

    function automatic string region_tag(int a);
        if (a == 0) return "R2";
        if (a < 8)  return "R3";
        if (a < 16) return "R5";
        return "R4";
    endfunction

    task automatic step(input logic [1:0] c, input bit we, input int wa,
                        input logic [31:0] wd, input int ra, input int rb,
                        input bit mwe, input logic [N-1:0] mwd);
        int st, rt, nw, ws, ea, eb;
        bit ovf_e, unf_e, trap, eff;
        string ta, tb;
        @(negedge clk);
        chk(int'(cwp) == cwp_m, last_trap ? "R9" : "R6", "cwp", cwp, cwp_m);
        chk(mask == mask_m, "R10", "mask", mask, mask_m);
        cmd = c; wr_en = we; wr_addr = 5'(wa); wr_data = wd;
        rd_a_addr = 5'(ra); rd_b_addr = 5'(rb);
        mask_wr_en = mwe; mask_wr_data = mwd;
        #1;
        st = (cwp_m + N - 1) % N;
        rt = (cwp_m + 1) % N;
        ovf_e = (c == 2'b01) && mask_m[st];
        unf_e = (c == 2'b10) && mask_m[rt];
        trap = ovf_e || unf_e;
        nw = trap ? cwp_m : (c == 2'b01) ? st : (c == 2'b10) ? rt : cwp_m;
        eff = we && !trap && wa != 0;
        ws = slot(wa, nw);
        ea = (ra == 0) ? 0 : (eff && slot(ra, cwp_m) == ws) ? int'(wd) : int'(mdl[slot(ra, cwp_m)]);
        eb = (rb == 0) ? 0 : (eff && slot(rb, cwp_m) == ws) ? int'(wd) : int'(mdl[slot(rb, cwp_m)]);
        ta = (eff && ra != 0 && slot(ra, cwp_m) == ws) ? "R8" :
             ((c == 2'b01 || c == 2'b10) && !trap) ? "R7" : region_tag(ra);
        tb = (eff && rb != 0 && slot(rb, cwp_m) == ws) ? "R8" :
             ((c == 2'b01 || c == 2'b10) && !trap) ? "R7" : region_tag(rb);
        chk(rd_a_data == 32'(ea), ta, "rd_a_data", rd_a_data, 32'(ea));
        chk(rd_b_data == 32'(eb), tb, "rd_b_data", rd_b_data, 32'(eb));
        chk(win_ovf == ovf_e, "R9", "win_ovf", win_ovf, ovf_e);
        chk(win_unf == unf_e, "R9", "win_unf", win_unf, unf_e);
        @(posedge clk);
        if (eff) mdl[ws] = wd;
        cwp_m = nw;
        last_trap = trap;
        if (mwe) mask_m = mwd;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < MSZ; i++) mdl[i] = '0;
        cwp_m = 0; mask_m = '0; last_trap = 1'b0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // R1: reset state across windows
        @(negedge clk);
        chk(cwp == '0, "R1", "cwp after reset", cwp, 0);
        chk(mask == '0, "R1", "mask after reset", mask, 0);
        chk(!win_ovf && !win_unf, "R1", "flags after reset", {win_ovf, win_unf}, 0);
        for (int a = 0; a < 32; a++) begin
            rd_a_addr = 5'(a);
            #0.1;
            chk(rd_a_data == '0, "R1", "reg after reset", rd_a_data, 0);
        end

        // R2: write to register 0 is dropped
        step(2'b00, 1, 0, 32'hDEAD_BEEF, 0, 0, 0, '0);
        step(2'b00, 0, 0, 0, 0, 0, 0, '0);
        // R3: global shared across a save
        step(2'b00, 1, 3, 32'h1234_5678, 3, 0, 0, '0);
        // R5: out 1 in window 0 becomes in 1 in window N-1 (wrap R6)
        step(2'b00, 1, 9, 32'hA5A5_0009, 9, 0, 0, '0);
        step(2'b01, 0, 0, 0, 9, 3, 0, '0);
        step(2'b00, 0, 0, 0, 25, 3, 0, '0);
        // R5 reverse: in 2 in window N-1, restore to 0, read out 2
        step(2'b00, 1, 26, 32'h0BAD_0026, 0, 0, 0, '0);
        step(2'b10, 0, 0, 0, 0, 0, 0, '0);
        step(2'b00, 0, 0, 0, 10, 26, 0, '0);
        // R7: save writes in new window while reading old
        step(2'b01, 1, 24, 32'h7777_0024, 8, 24, 0, '0);
        step(2'b10, 1, 8, 32'h8888_0008, 24, 8, 0, '0);
        // R8: forward on same cycle
        step(2'b00, 1, 17, 32'hF0F0_0017, 17, 17, 0, '0);
        // R9/R10: block save into window N-1 from 0
        step(2'b00, 0, 0, 0, 0, 0, 1, N'(1) << (N - 1));
        step(2'b01, 1, 17, 32'h5555_5555, 17, 0, 0, '0);
        step(2'b00, 0, 0, 0, 17, 0, 0, '0);
        step(2'b00, 0, 0, 0, 0, 0, 1, N'(2));
        step(2'b10, 1, 3, 32'h6666_6666, 3, 0, 0, '0);
        step(2'b00, 0, 0, 0, 3, 0, 1, '0);
        // R6: full wrap in both directions
        for (int i = 0; i < N + 1; i++) step(2'b01, 0, 0, 0, 16, 24, 0, '0);
        for (int i = 0; i < N + 1; i++) step(2'b10, 0, 0, 0, 16, 24, 0, '0);
        step(2'b11, 0, 0, 0, 0, 0, 0, '0);

        // Random mix
        for (int i = 0; i < 4000; i++) begin
            int r, wa, ra, rb;
            logic [1:0] c;
            bit mwe;
            logic [N-1:0] mwd;
            r = $urandom % 8;
            c = (r == 0) ? 2'b01 : (r == 1) ? 2'b10 : (r == 7) ? 2'b11 : 2'b00;
            wa = $urandom % 32;
            ra = ($urandom % 4 == 0) ? wa : $urandom % 32;
            rb = ($urandom % 4 == 0) ? ((wa + 16) % 32) : $urandom % 32;
            mwe = ($urandom % 25 == 0);
            mwd = ($urandom % 2) ? '0 : (N'(1) << ($urandom % N));
            step(c, ($urandom % 3 != 0), wa, $urandom, ra, rb, mwe, mwd);
        end
        @(negedge clk);
        chk(int'(cwp) == cwp_m, "R6", "final cwp", cwp, cwp_m);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule